// File: doc/BRIEF.md
# Completion Ring Poster

This block owns one circular completion ring that lives in host memory. A request side hands it completion records, each holding a command tag, a 15-bit status code, the identifier of the submission queue the command came from, and that submission queue's head index at the time the record was formed. For every record the block works out where in host memory the entry belongs, packs the status code together with the ring's current phase tag, and presents the finished entry as a single write request that is held until the memory side takes it.

The block keeps the producer index (tail), the consumer index (head) reported by the host through a doorbell, and a phase tag that flips each time the tail wraps. It refuses new records while the ring is full, leaving them waiting at its input. When the host frees space with a head doorbell after the ring was full, the block pulses a restart to the submission queues that feed it. It raises a one-cycle interrupt pulse after each written entry and after a doorbell that leaves unread entries, but only while interrupts are enabled for this ring.

Top module: `cq_ring_poster`

## Requirements
- R1: The 16-bit status on the write port is the 15-bit record status code in bits 15:1 and the phase tag in bit 0; the phase tag is 1 after reset or `q_init`.
- R2: After an entry is taken at tail index `q_size-1`, the tail becomes 0 and the phase tag inverts; at any other index the tail only increments.
- R3: The ring is full when (tail+1) mod `q_size` equals head; while full, `rec_ready` is low, no write is started, and a waiting record stays at the input until space is freed.
- R4: `wr_addr` equals `base_addr` plus the tail index of the entry multiplied by 2 to the power `entry_exp`.
- R5: `wr_cid`, `wr_sqid` and `wr_sqhead` carry the command tag, submission queue identifier and submission queue head of the record that was taken.
- R6: One cycle after a write handshake (`wr_valid` and `wr_ready` high at a rising edge), `irq` pulses for one cycle when `irq_en` is high, and stays low when `irq_en` is low.
- R7: A head doorbell whose value is greater than or equal to `q_size` is ignored: head, `sq_restart` and `irq` are unaffected.
- R8: An accepted head doorbell that arrives while the ring is full produces a one-cycle `sq_restart` pulse in the next cycle; one that arrives while not full does not.
- R9: After an accepted head doorbell, `irq` pulses in the next cycle if `irq_en` is high and the tail differs from the new head.
- R10: Reset or a `q_init` pulse sets head and tail to 0, phase to 1, and drops any write not yet accepted.
- R11: Once raised, `wr_valid` stays high with all write fields unchanged until the handshake; at most one entry is outstanding, so a new record is taken only when no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_init | input | 1 | Ring (re)creation or controller disable pulse |
| q_size | input | 12 | Number of ring slots, 2 or more |
| base_addr | input | 64 | Ring base byte address in host memory |
| entry_exp | input | 4 | Entry size exponent (bytes = 2^entry_exp) |
| irq_en | input | 1 | Interrupt enable for this ring |
| rec_valid | input | 1 | Completion record offered |
| rec_ready | output | 1 | Completion record taken this cycle |
| rec_cid | input | 16 | Command tag |
| rec_status | input | 15 | Status code |
| rec_sqid | input | 16 | Originating submission queue identifier |
| rec_sqhead | input | 16 | Originating submission queue head |
| wr_valid | output | 1 | Entry write request |
| wr_ready | input | 1 | Memory side accepts the write |
| wr_addr | output | 64 | Entry byte address |
| wr_cid | output | 16 | Command tag of the entry |
| wr_status | output | 16 | Status code with phase tag in bit 0 |
| wr_sqid | output | 16 | Submission queue identifier of the entry |
| wr_sqhead | output | 16 | Submission queue head of the entry |
| db_valid | input | 1 | Head doorbell write |
| db_head | input | 16 | New head value from the host |
| tail_o | output | 11 | Current tail index |
| head_o | output | 11 | Current head index |
| irq | output | 1 | One-cycle interrupt request |
| sq_restart | output | 1 | One-cycle restart to feeding submission queues |

## Verification
A corrupted tail shows up on the very next entry as a wrong `wr_addr`, and a phase tag out of step shows as a wrong bit 0 of `wr_status` on the first entry after a wrap, so both are exposed by the first write after the fault. A wrong head or full flag shows one cycle after a doorbell, either as `rec_ready` held low with space available, as an entry written over unread slots, or as a missing or spurious `sq_restart`. Interrupt gating faults appear one cycle after the write handshake or doorbell that should or should not have produced `irq`.

// File: rtl/cq_pkg.sv
package cq_pkg;
   localparam int CID_W  = 16;
   localparam int QID_W  = 16;
   localparam int CODE_W = 15;
   localparam int STAT_W = CODE_W + 1;

   typedef struct packed {
      logic [CID_W-1:0] cid;
      logic [QID_W-1:0] sqid;
      logic [QID_W-1:0] sqhead;
   } cq_meta_t;
endpackage

// File: rtl/cq_ring_ptrs.sv
module cq_ring_ptrs #(
   parameter int MAX_ENTRIES = 2048,
   parameter int DB_W        = 16,
   localparam int PTR_W      = $clog2(MAX_ENTRIES),
   localparam int SZ_W       = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             q_init,
   input  logic [SZ_W-1:0]  q_size,
   input  logic             advance,
   input  logic             db_valid,
   input  logic [DB_W-1:0]  db_head,
   output logic [PTR_W-1:0] tail,
   output logic [PTR_W-1:0] head,
   output logic             phase,
   output logic             full,
   output logic             db_pending,
   output logic             restart
);
   logic [SZ_W-1:0] tail_inc;
   logic [SZ_W-1:0] tail_nxt;
   logic            wrap;
   logic            db_ok;
   logic [DB_W-1:0] size_ext;

   assign tail_inc   = {1'b0, tail} + SZ_W'(1);
   assign wrap       = (tail_inc == q_size);
   assign tail_nxt   = wrap ? '0 : tail_inc;
   assign full       = (tail_nxt == {1'b0, head});
   assign size_ext   = DB_W'(q_size);
   assign db_ok      = db_valid && (db_head < size_ext);
   assign db_pending = db_ok && (PTR_W'(db_head) != tail);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail    <= '0;
         head    <= '0;
         phase   <= 1'b1;
         restart <= 1'b0;
      end else if (q_init) begin
         tail    <= '0;
         head    <= '0;
         phase   <= 1'b1;
         restart <= 1'b0;
      end else begin
         restart <= db_ok && full;
         if (db_ok)
            head <= PTR_W'(db_head);
         if (advance) begin
            tail <= PTR_W'(tail_nxt);
            if (wrap)
               phase <= ~phase;
         end
      end
   end

   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tail == '0 && $past(tail) != '0 && !$past(q_init)) |-> (phase != $past(phase))); // R2
   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n || q_init)
      full |=> $stable(tail)); // R3
   AST_BAD_DB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || q_init)
      (db_valid && db_head >= size_ext) |=> $stable(head)); // R7
   AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> ($past(full) && $past(db_valid))); // R8
endmodule

// File: rtl/cq_entry_build.sv
module cq_entry_build #(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 11,
   parameter int EXP_W  = 4
) (
   input  logic [ADDR_W-1:0]       base_addr,
   input  logic [PTR_W-1:0]        tail,
   input  logic [EXP_W-1:0]        entry_exp,
   input  logic [cq_pkg::CODE_W-1:0] code,
   input  logic                    phase,
   output logic [ADDR_W-1:0]       addr,
   output logic [cq_pkg::STAT_W-1:0] status
);
   logic [ADDR_W-1:0] stg [0:EXP_W];

   assign stg[0] = ADDR_W'(tail);

   for (genvar k = 0; k < EXP_W; k++) begin : g_shift
      assign stg[k+1] = entry_exp[k] ? (stg[k] << (1 << k)) : stg[k];
   end

   assign addr   = base_addr + stg[EXP_W];
   assign status = {code, phase};
endmodule

// File: rtl/cq_ring_poster.sv
module cq_ring_poster #(
   parameter int MAX_ENTRIES = 2048,
   parameter int ADDR_W      = 64,
   parameter int EXP_W       = 4,
   parameter int DB_W        = 16,
   localparam int PTR_W      = $clog2(MAX_ENTRIES),
   localparam int SZ_W       = PTR_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       q_init,
   input  logic [SZ_W-1:0]            q_size,
   input  logic [ADDR_W-1:0]          base_addr,
   input  logic [EXP_W-1:0]           entry_exp,
   input  logic                       irq_en,
   input  logic                       rec_valid,
   output logic                       rec_ready,
   input  logic [cq_pkg::CID_W-1:0]   rec_cid,
   input  logic [cq_pkg::CODE_W-1:0]  rec_status,
   input  logic [cq_pkg::QID_W-1:0]   rec_sqid,
   input  logic [cq_pkg::QID_W-1:0]   rec_sqhead,
   output logic                       wr_valid,
   input  logic                       wr_ready,
   output logic [ADDR_W-1:0]          wr_addr,
   output logic [cq_pkg::CID_W-1:0]   wr_cid,
   output logic [cq_pkg::STAT_W-1:0]  wr_status,
   output logic [cq_pkg::QID_W-1:0]   wr_sqid,
   output logic [cq_pkg::QID_W-1:0]   wr_sqhead,
   input  logic                       db_valid,
   input  logic [DB_W-1:0]            db_head,
   output logic [PTR_W-1:0]           tail_o,
   output logic [PTR_W-1:0]           head_o,
   output logic                       irq,
   output logic                       sq_restart
);
   import cq_pkg::*;

   if (MAX_ENTRIES < 2) begin : g_bad_depth
      $error("MAX_ENTRIES must be at least 2");
   end
   if (DB_W < SZ_W) begin : g_bad_db
      $error("DB_W must cover the queue size width");
   end
   if (ADDR_W < 16) begin : g_bad_addr
      $error("ADDR_W too narrow");
   end

   logic              phase;
   logic              full;
   logic              db_pending;
   logic              take;
   logic              wr_fire;
   logic              wr_vld_q;
   logic [ADDR_W-1:0] addr_c;
   logic [STAT_W-1:0] stat_c;
   cq_meta_t          meta_q;
   logic [ADDR_W-1:0] addr_q;
   logic [STAT_W-1:0] stat_q;
   logic              irq_q;

   assign rec_ready = !wr_vld_q && !full;
   assign take      = rec_valid && rec_ready;
   assign wr_fire   = wr_vld_q && wr_ready;

   cq_ring_ptrs #(.MAX_ENTRIES(MAX_ENTRIES), .DB_W(DB_W)) u_ptrs (
      .clk        (clk),
      .rst_n      (rst_n),
      .q_init     (q_init),
      .q_size     (q_size),
      .advance    (take),
      .db_valid   (db_valid),
      .db_head    (db_head),
      .tail       (tail_o),
      .head       (head_o),
      .phase      (phase),
      .full       (full),
      .db_pending (db_pending),
      .restart    (sq_restart)
   );

   cq_entry_build #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .EXP_W(EXP_W)) u_build (
      .base_addr (base_addr),
      .tail      (tail_o),
      .entry_exp (entry_exp),
      .code      (rec_status),
      .phase     (phase),
      .addr      (addr_c),
      .status    (stat_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_vld_q <= 1'b0;
         addr_q   <= '0;
         stat_q   <= '0;
         meta_q   <= '0;
         irq_q    <= 1'b0;
      end else if (q_init) begin
         wr_vld_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= irq_en && (wr_fire || db_pending);
         if (take) begin
            wr_vld_q <= 1'b1;
            addr_q   <= addr_c;
            stat_q   <= stat_c;
            meta_q   <= '{cid: rec_cid, sqid: rec_sqid, sqhead: rec_sqhead};
         end else if (wr_fire) begin
            wr_vld_q <= 1'b0;
         end
      end
   end

   assign wr_valid  = wr_vld_q;
   assign wr_addr   = addr_q;
   assign wr_status = stat_q;
   assign wr_cid    = meta_q.cid;
   assign wr_sqid   = meta_q.sqid;
   assign wr_sqhead = meta_q.sqhead;
   assign irq       = irq_q;

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n || q_init)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_status)
                                   && $stable(wr_cid))); // R11
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !rec_ready); // R11
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(irq_en)); // R6
endmodule

// File: tb/tb_cq_ring_poster.sv
module tb_cq_ring_poster;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        q_init = 1'b0;
   logic [11:0] q_size = 12'd4;
   logic [63:0] base_addr = 64'h1000;
   logic [3:0]  entry_exp = 4'd4;
   logic        irq_en = 1'b1;
   logic        rec_valid = 1'b0;
   logic        rec_ready;
   logic [15:0] rec_cid = '0;
   logic [14:0] rec_status = '0;
   logic [15:0] rec_sqid = '0;
   logic [15:0] rec_sqhead = '0;
   logic        wr_valid;
   logic        wr_ready = 1'b0;
   logic [63:0] wr_addr;
   logic [15:0] wr_cid, wr_status, wr_sqid, wr_sqhead;
   logic        db_valid = 1'b0;
   logic [15:0] db_head = '0;
   logic [10:0] tail_o, head_o;
   logic        irq, sq_restart;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   cq_ring_poster dut (
      .clk(clk), .rst_n(rst_n), .q_init(q_init), .q_size(q_size),
      .base_addr(base_addr), .entry_exp(entry_exp), .irq_en(irq_en),
      .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_cid(rec_cid),
      .rec_status(rec_status), .rec_sqid(rec_sqid), .rec_sqhead(rec_sqhead),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_cid(wr_cid), .wr_status(wr_status), .wr_sqid(wr_sqid),
      .wr_sqhead(wr_sqhead), .db_valid(db_valid), .db_head(db_head),
      .tail_o(tail_o), .head_o(head_o), .irq(irq), .sq_restart(sq_restart)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Offer a record and wait until it is taken; leaves the write pending.
   task automatic offer(input logic [15:0] cid, input logic [14:0] code,
                        input logic [15:0] sqid, input logic [15:0] sqh);
      @(negedge clk);
      rec_valid = 1'b1; rec_cid = cid; rec_status = code;
      rec_sqid = sqid; rec_sqhead = sqh;
      while (!rec_ready) @(negedge clk);
      @(posedge clk); #1 rec_valid = 1'b0;
      @(negedge clk);
   endtask

   // Complete the pending write and check the interrupt one cycle later.
   task automatic finish_write(input logic exp_irq, input string tag);
      @(negedge clk); wr_ready = 1'b1;
      @(posedge clk); #1 wr_ready = 1'b0;
      @(negedge clk);
      chk({tag, " irq after write"}, irq, exp_irq);
      chk({tag, " wr_valid dropped"}, wr_valid, 0);
   endtask

   task automatic doorbell(input logic [15:0] h);
      @(negedge clk); db_valid = 1'b1; db_head = h;
      @(posedge clk); #1 db_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R10 reset wr_valid", wr_valid, 0);
      chk("R10 reset tail", tail_o, 0);
      chk("R10 reset head", head_o, 0);
      chk("R10 reset irq", irq, 0);
      chk("R3 reset ready", rec_ready, 1);
   endtask

   task automatic t_first_entry;
      offer(16'hA001, 15'h1234, 16'h0003, 16'h0011);
      chk("R4 addr slot0", wr_addr, 64'h1000);
      chk("R1 status phase1", wr_status, {15'h1234, 1'b1});
      chk("R5 cid", wr_cid, 16'hA001);
      chk("R5 sqid", wr_sqid, 16'h0003);
      chk("R5 sqhead", wr_sqhead, 16'h0011);
      chk("R11 no second take", rec_ready, 0);
      repeat (3) @(negedge clk);
      chk("R11 held valid", wr_valid, 1);
      chk("R11 held addr", wr_addr, 64'h1000);
      finish_write(1'b1, "R6");
   endtask

   task automatic t_fill_and_free;
      offer(16'hA002, 15'h0002, 16'h1, 16'h2);
      chk("R4 addr slot1", wr_addr, 64'h1010);
      finish_write(1'b1, "R6 slot1");
      offer(16'hA003, 15'h0003, 16'h1, 16'h3);
      chk("R4 addr slot2", wr_addr, 64'h1020);
      finish_write(1'b1, "R6 slot2");
      chk("R2 tail 3", tail_o, 3);
      chk("R3 full ready low", rec_ready, 0);
      @(negedge clk);
      rec_valid = 1'b1; rec_cid = 16'hA004; rec_status = 15'h0044;
      rec_sqid = 16'h2; rec_sqhead = 16'h5;
      repeat (3) @(negedge clk);
      chk("R3 no write while full", wr_valid, 0);
      chk("R3 tail stuck", tail_o, 3);
      // out-of-range doorbell, record still waiting
      @(negedge clk); db_valid = 1'b1; db_head = 16'd4;
      @(posedge clk); #1 db_valid = 1'b0;
      @(negedge clk);
      chk("R7 head unchanged", head_o, 0);
      chk("R7 no restart", sq_restart, 0);
      chk("R7 no irq", irq, 0);
      chk("R7 still full", rec_ready, 0);
      // valid doorbell frees space
      @(negedge clk); db_valid = 1'b1; db_head = 16'd2;
      @(posedge clk); #1 db_valid = 1'b0;
      @(negedge clk);
      chk("R8 restart pulse", sq_restart, 1);
      chk("R9 irq on unread", irq, 1);
      chk("R7 head moved", head_o, 2);
      chk("R3 ready after free", rec_ready, 1);
      @(posedge clk); #1 rec_valid = 1'b0;
      @(negedge clk);
      chk("R8 restart one cycle", sq_restart, 0);
      chk("R3 pending addr slot3", wr_addr, 64'h1030);
      chk("R1 pending phase1", wr_status, {15'h0044, 1'b1});
      chk("R5 pending cid", wr_cid, 16'hA004);
      chk("R2 tail wrapped", tail_o, 0);
      finish_write(1'b1, "R6 slot3");
   endtask

   task automatic t_after_wrap;
      offer(16'hB000, 15'h7FFF, 16'h9, 16'h8);
      chk("R4 addr wrap slot0", wr_addr, 64'h1000);
      chk("R2 phase inverted", wr_status, {15'h7FFF, 1'b0});
      finish_write(1'b1, "R6 wrap");
      chk("R3 full again", rec_ready, 0);
      doorbell(16'd1);
      chk("R8 restart when full", sq_restart, 1);
      chk("R9 no irq when empty", irq, 0);
      irq_en = 1'b0;
      offer(16'hB001, 15'h0010, 16'h9, 16'h9);
      chk("R4 addr slot1 wrap", wr_addr, 64'h1010);
      chk("R1 phase0 kept", wr_status, {15'h0010, 1'b0});
      finish_write(1'b0, "R6 disabled");
      doorbell(16'd1);
      chk("R8 no restart when not full", sq_restart, 0);
      chk("R9 irq gated off", irq, 0);
      irq_en = 1'b1;
      doorbell(16'd1);
      chk("R9 irq tail!=head", irq, 1);
   endtask

   task automatic t_init_and_size;
      offer(16'hC000, 15'h0001, 16'h1, 16'h1);
      @(negedge clk); q_init = 1'b1;
      @(posedge clk); #1 q_init = 1'b0;
      @(negedge clk);
      chk("R10 init drops write", wr_valid, 0);
      chk("R10 init tail", tail_o, 0);
      chk("R10 init head", head_o, 0);
      entry_exp = 4'd6;
      offer(16'hC001, 15'h0005, 16'h1, 16'h1);
      chk("R10 phase1 after init", wr_status, {15'h0005, 1'b1});
      chk("R4 exp6 slot0", wr_addr, 64'h1000);
      finish_write(1'b1, "R6 exp6");
      offer(16'hC002, 15'h0006, 16'h1, 16'h1);
      chk("R4 exp6 slot1", wr_addr, 64'h1040);
      finish_write(1'b1, "R6 exp6b");
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_first_entry();
      t_fill_and_free();
      t_after_wrap();
      t_init_and_size();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule